// File: doc/BRIEF.md
# Snoop Receive Buffer with Reserved Reply Entry

This block sits on the receive side of a split-transaction bus interface for one processor node. While the node's own bus request is outstanding, requests snooped from other nodes and the reply to the node's own request keep arriving from the bus. The block has to hold them until the local logic drains them. It stores incoming requests in a first-in first-out queue with one entry per processor. It also keeps one more entry that only a reply may use. Because that entry is always free for the reply, the node can never deadlock waiting for its own data behind a queue full of foreign requests.

When every request entry is taken, a further incoming request is refused with a NACK in the same cycle and is not stored. On the drain side, a held reply bypasses any queued requests. On the send side, a small selector picks what the node puts on the bus next. A pending response always wins over a new request. After one of the node's own requests has been NACKed by the bus, the selector raises a high-priority flag towards the global arbiter. That flag stays up until the retried request is taken, which guarantees forward progress.

Top module: `snoop_rx_buffer`

## Requirements
- R1: Incoming requests (bus_kind = 0) are accepted while fewer than P (parameter, default 4) request entries are held, and they leave on the drain port in arrival order.
- R2: An incoming reply (bus_kind = 1) is accepted whenever the reply entry is empty, even while all P request entries are occupied; requests never occupy the reply entry.
- R3: An incoming request that arrives while P request entries are held raises bus_nack combinationally in that same cycle and is not stored; the drain sequence shows no trace of it.
- R4: While a reply is held, the drain port presents the reply (drain_kind = 1) ahead of any queued request.
- R5: A reply that arrives while the reply entry is already occupied raises bus_nack in that cycle and is dropped; the held reply is kept unchanged.
- R6: drain_vld is high exactly when at least one entry is held. An entry is removed on a cycle with drain_vld and drain_rdy both high, and held entries stay in place while drain_rdy is low.
- R7: When own_rsp_pend is high, out_sel_rsp is high and out_sel_req is low. out_sel_req is high only when own_req_pend is high and own_rsp_pend is low, and the two selects are never high together.
- R8: A cycle with own_req_nacked high sets out_prio_hi from the next cycle onward. The flag stays high until a cycle with out_take and out_sel_req both high and own_req_nacked low, and it is low from the cycle after that.
- R9: After reset, no entry is held (drain_vld low), bus_nack is low for idle bus inputs, and out_prio_hi is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_vld | input | 1 | Incoming bus transaction present this cycle |
| bus_kind | input | 1 | 0 = request, 1 = reply |
| bus_tag | input | TAG_W | Transaction tag |
| bus_addr | input | ADDR_W | Transaction address |
| bus_nack | output | 1 | Incoming transaction refused this cycle |
| drain_vld | output | 1 | An entry is presented on the drain port |
| drain_rdy | input | 1 | Local side takes the presented entry |
| drain_kind | output | 1 | Kind of the presented entry |
| drain_tag | output | TAG_W | Tag of the presented entry |
| drain_addr | output | ADDR_W | Address of the presented entry |
| own_rsp_pend | input | 1 | Node has a response waiting to be sent |
| own_req_pend | input | 1 | Node has a new request waiting to be sent |
| out_take | input | 1 | Bus accepted the selected outbound item |
| own_req_nacked | input | 1 | Node's own request was NACKed on the bus |
| out_sel_rsp | output | 1 | Outbound selects the response |
| out_sel_req | output | 1 | Outbound selects the request |
| out_prio_hi | output | 1 | Raised-priority flag to the global arbiter |

## Verification
Every cycle, the assertions check that the request count never exceeds P and that a request meeting a full queue is NACKed while a reply meeting an empty reply entry is not. They also check that a held reply is the item on the drain port, that the outbound selects are one-hot-or-none with the response winning, and that a NACK of the node's request raises the priority flag. Only the bench scenarios can show that data leaves in arrival order and that a refused request or second reply leaves no trace in the drain sequence. The same holds for the reply slipping in just after the queue filled, and for the priority flag holding across idle cycles before dropping after the retried request is taken.

// File: rtl/snprx_pkg.sv
package snprx_pkg;
  typedef enum logic {
    KIND_REQ = 1'b0,
    KIND_RPL = 1'b1
  } kind_e;
endpackage

// File: rtl/snprx_req_fifo.sv
module snprx_req_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head_data,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, wr_ptr_nxt;
  logic [PW-1:0] rd_ptr, rd_ptr_nxt;
  logic [CW-1:0] cnt_nxt;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wr_ptr_nxt = push ? ptr_inc(wr_ptr) : wr_ptr;
    rd_ptr_nxt = pop  ? ptr_inc(rd_ptr) : rd_ptr;
    cnt_nxt    = cnt;
    if (push && !pop)      cnt_nxt = cnt + CW'(1);
    else if (pop && !push) cnt_nxt = cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      cnt    <= cnt_nxt;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (push && (wr_ptr == PW'(i))) mem[i] <= push_data;
    end
  end

  assign head_data = mem[rd_ptr];
  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
endmodule

// File: rtl/snprx_rpl_slot.sv
module snprx_rpl_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         clear,
  output logic         held,
  output logic [W-1:0] data
);
  logic held_nxt;

  always_comb begin
    held_nxt = held;
    if (load)       held_nxt = 1'b1;
    else if (clear) held_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= held_nxt;
  end

  always_ff @(posedge clk) begin
    if (load) data <= load_data;
  end
endmodule

// File: rtl/snprx_out_arb.sv
module snprx_out_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic rsp_pend,
  input  logic req_pend,
  input  logic take,
  input  logic req_nacked,
  output logic sel_rsp,
  output logic sel_req,
  output logic prio_hi
);
  logic prio_nxt;

  always_comb begin
    sel_rsp  = rsp_pend;
    sel_req  = req_pend && !rsp_pend;
    prio_nxt = prio_hi;
    if (req_nacked)           prio_nxt = 1'b1;
    else if (take && sel_req) prio_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prio_hi <= 1'b0;
    else        prio_hi <= prio_nxt;
  end
endmodule

// File: rtl/snoop_rx_buffer.sv
module snoop_rx_buffer
  import snprx_pkg::*;
#(
  parameter int P      = 4,
  parameter int TAG_W  = 3,
  parameter int ADDR_W = 16,
  localparam int W     = 1 + TAG_W + ADDR_W,
  localparam int CW    = $clog2(P + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_vld,
  input  logic              bus_kind,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              bus_nack,
  output logic              drain_vld,
  input  logic              drain_rdy,
  output logic              drain_kind,
  output logic [TAG_W-1:0]  drain_tag,
  output logic [ADDR_W-1:0] drain_addr,
  input  logic              own_rsp_pend,
  input  logic              own_req_pend,
  input  logic              out_take,
  input  logic              own_req_nacked,
  output logic              out_sel_rsp,
  output logic              out_sel_req,
  output logic              out_prio_hi
);
  logic          in_req, in_rpl;
  logic          push_req, load_rpl, pop_any, pop_req, clr_rpl;
  logic          req_full, req_empty, rpl_held;
  logic [CW-1:0] req_cnt;
  logic [W-1:0]  in_item, req_head, rpl_item, out_item;

  assign in_item  = {bus_kind, bus_tag, bus_addr};
  assign in_req   = bus_vld && (kind_e'(bus_kind) == KIND_REQ);
  assign in_rpl   = bus_vld && (kind_e'(bus_kind) == KIND_RPL);
  assign bus_nack = (in_req && req_full) || (in_rpl && rpl_held);
  assign push_req = in_req && !req_full;
  assign load_rpl = in_rpl && !rpl_held;

  assign drain_vld = rpl_held || !req_empty;
  assign pop_any   = drain_vld && drain_rdy;
  assign clr_rpl   = pop_any && rpl_held;
  assign pop_req   = pop_any && !rpl_held;
  assign out_item  = rpl_held ? rpl_item : req_head;
  assign {drain_kind, drain_tag, drain_addr} = out_item;

  snprx_req_fifo #(.DEPTH(P), .W(W)) u_req_q (
    .clk(clk), .rst_n(rst_n), .push(push_req), .push_data(in_item),
    .pop(pop_req), .head_data(req_head), .cnt(req_cnt),
    .full(req_full), .empty(req_empty)
  );

  snprx_rpl_slot #(.W(W)) u_rpl (
    .clk(clk), .rst_n(rst_n), .load(load_rpl), .load_data(in_item),
    .clear(clr_rpl), .held(rpl_held), .data(rpl_item)
  );

  snprx_out_arb u_arb (
    .clk(clk), .rst_n(rst_n), .rsp_pend(own_rsp_pend), .req_pend(own_req_pend),
    .take(out_take), .req_nacked(own_req_nacked),
    .sel_rsp(out_sel_rsp), .sel_req(out_sel_req), .prio_hi(out_prio_hi)
  );
endmodule

// File: rtl/snoop_rx_buffer_chk.sv
module snoop_rx_buffer_chk #(
  parameter int P  = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_vld,
  input logic          bus_kind,
  input logic          bus_nack,
  input logic          drain_vld,
  input logic          drain_kind,
  input logic          rpl_held,
  input logic [CW-1:0] req_cnt,
  input logic          own_rsp_pend,
  input logic          own_req_nacked,
  input logic          out_sel_rsp,
  input logic          out_sel_req,
  input logic          out_prio_hi
);
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_cnt <= CW'(P));

  assert_rpl_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && bus_kind && !rpl_held) |-> !bus_nack);

  assert_full_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && !bus_kind && req_cnt == CW'(P)) |-> bus_nack);

  assert_rpl_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_held |-> (drain_vld && drain_kind));

  assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_sel_rsp, out_sel_req}));

  assert_rsp_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    own_rsp_pend |-> (out_sel_rsp && !out_sel_req));

  assert_prio_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    own_req_nacked |=> out_prio_hi);
endmodule

bind snoop_rx_buffer snoop_rx_buffer_chk #(.P(P), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_kind(bus_kind),
  .bus_nack(bus_nack), .drain_vld(drain_vld), .drain_kind(drain_kind),
  .rpl_held(rpl_held), .req_cnt(req_cnt), .own_rsp_pend(own_rsp_pend),
  .own_req_nacked(own_req_nacked), .out_sel_rsp(out_sel_rsp),
  .out_sel_req(out_sel_req), .out_prio_hi(out_prio_hi)
);

// File: tb/snoop_rx_buffer_bench.sv
`timescale 1ns/1ps
module snoop_rx_buffer_bench;
  localparam int P = 4, TAG_W = 3, ADDR_W = 16, W = 1 + TAG_W + ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_vld = 0, bus_kind = 0, drain_rdy = 0;
  logic [TAG_W-1:0] bus_tag = '0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic own_rsp_pend = 0, own_req_pend = 0, out_take = 0, own_req_nacked = 0;
  logic bus_nack, drain_vld, drain_kind, out_sel_rsp, out_sel_req, out_prio_hi;
  logic [TAG_W-1:0] drain_tag;
  logic [ADDR_W-1:0] drain_addr;

  int n_cmp = 0, n_bad = 0;
  bit mon_on = 0, done = 0;
  logic [W-1:0] exp_req_q[$];
  logic [W-1:0] exp_rpl_q[$];
  logic prio_m = 0;

  always #4 clk = ~clk;

  snoop_rx_buffer #(.P(P), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_snoop_rx_buffer (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic k, input int t, input int a);
    @(posedge clk); #1;
    bus_vld = v; bus_kind = k; bus_tag = TAG_W'(t); bus_addr = ADDR_W'(a);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0);
  endtask

  // monitor: model-based compare, samples 1 ns before each rising edge
  initial begin
    forever begin
      logic exp_nack, exp_vld;
      logic [W-1:0] got, want;
      @(negedge clk); #3;
      if (mon_on) begin
        exp_nack = bus_vld && (bus_kind ? (exp_rpl_q.size() != 0) : (exp_req_q.size() == P));
        chk(bus_kind ? "R5" : "R3", "bus_nack", 32'(bus_nack), 32'(exp_nack));
        exp_vld = (exp_req_q.size() != 0) || (exp_rpl_q.size() != 0);
        chk("R6", "drain_vld", 32'(drain_vld), 32'(exp_vld));
        if (drain_vld && drain_rdy && exp_vld) begin
          got = {drain_kind, drain_tag, drain_addr};
          if (exp_rpl_q.size() != 0) begin
            want = exp_rpl_q.pop_front();
            chk("R4", "drain reply", 32'(got), 32'(want));
          end else begin
            want = exp_req_q.pop_front();
            chk("R1", "drain request", 32'(got), 32'(want));
          end
        end
        if (bus_vld && !exp_nack) begin
          if (bus_kind) exp_rpl_q.push_back({bus_kind, bus_tag, bus_addr});
          else          exp_req_q.push_back({bus_kind, bus_tag, bus_addr});
        end
        chk("R7", "out_sel_rsp", 32'(out_sel_rsp), 32'(own_rsp_pend));
        chk("R7", "out_sel_req", 32'(out_sel_req), 32'(own_req_pend && !own_rsp_pend));
        chk("R8", "out_prio_hi", 32'(out_prio_hi), 32'(prio_m));
        if (own_req_nacked) prio_m = 1;
        else if (out_take && own_req_pend && !own_rsp_pend) prio_m = 0;
      end
    end
  end

  task automatic drain_all();
    @(posedge clk); #1; drain_rdy = 1; bus_vld = 0;
    for (int i = 0; i < 20 && (exp_req_q.size() + exp_rpl_q.size()) != 0; i++) @(posedge clk);
    #1; drain_rdy = 0;
  endtask

  initial begin
    #2;
    // R9: reset state
    #10;
    chk("R9", "drain_vld in reset", 32'(drain_vld), 0);
    chk("R9", "bus_nack in reset", 32'(bus_nack), 0);
    chk("R9", "out_prio_hi in reset", 32'(out_prio_hi), 0);
    @(posedge clk); #1; rst_n = 1;
    mon_on = 1;
    idle(2);

    // R1/R3/R2: fill all request entries, extra request NACKed, then a reply still accepted
    for (int i = 0; i < P; i++) drive(1, 0, i, 16'h1000 + i);
    drive(1, 0, 7, 16'hDEAD);           // R3 refused
    drive(1, 1, 5, 16'hBEEF);           // R2 accepted into reserved entry
    drive(1, 1, 6, 16'hCAFE);           // R5 refused, reply entry occupied
    idle(1);
    drive(0, 0, 0, 0);
    // R6: hold while drain_rdy low
    idle(3);
    drain_all();                         // R4 reply first, then R1 order
    idle(2);

    // R1/R6: streaming with drain always ready
    @(posedge clk); #1; drain_rdy = 1;
    for (int i = 0; i < 10; i++) drive(1, 0, i, 16'h2000 + 3 * i);
    drive(1, 1, 2, 16'h3333);
    drive(1, 0, 1, 16'h4444);
    idle(4);
    @(posedge clk); #1; drain_rdy = 0;

    // R4: reply arriving behind queued requests bypasses them
    drive(1, 0, 1, 16'h5001);
    drive(1, 0, 2, 16'h5002);
    drive(1, 1, 3, 16'h5003);
    drain_all();
    idle(2);

    // R7/R8: outbound selection and retry priority
    @(posedge clk); #1; own_rsp_pend = 1; own_req_pend = 1;
    @(posedge clk); #1; own_rsp_pend = 0;
    @(posedge clk); #1; own_req_nacked = 1;
    @(posedge clk); #1; own_req_nacked = 0; own_req_pend = 0;
    idle(3);
    @(posedge clk); #1; own_rsp_pend = 1; out_take = 1;   // response taken, flag kept
    @(posedge clk); #1; own_rsp_pend = 0; own_req_pend = 1; // request taken, flag drops
    @(posedge clk); #1; out_take = 0; own_req_pend = 0;
    idle(3);

    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule